// File: doc/BRIEF.md
# Laser safety shutdown controller

This block supervises the two enables of a laser transmitter: the bias current enable and the modulation current enable. It receives the already-digitized results of the analog monitoring circuits: an over-power comparator, an under-power comparator and an over-reference indication. It also receives a supply-good indication, an external disable request and a mode select. Every input is asynchronous to the block clock and passes through a two-flop synchronizer before the state machine uses it.

When the supply is good and disable is released, the controller waits a programmable turn-on time and then raises both enables. It then holds a programmable blanking window, so that transients of the power control loop are neither reported nor acted on. After the window it supervises the laser.

In latching mode, an over-power condition (fault) or an under-power condition (fail) drops both enables and latches the matching flag. The laser stays dark until disable is asserted and released, or until the supply goes bad and then good again. In non-latching mode, detections never shut the laser down, and each flag follows its live condition.

Top module: `laser_guard`

## Requirements
- R1: While rst_ni is low and after its release, both enables and both flags are 0 until the turn-on sequence starts.
- R2: bias_en_o and mod_en_o are always equal. Once disable_i has been high for 3 consecutive rising edges, both are 0.
- R3: Disable_i goes low or supply_ok_i goes high while the other condition already permits operation, before rising edge k. Both enables go high after edge k+2+ON_CYCLES, which is ON_CYCLES+3 edges after the input changed.
- R4: For BLANK_CYCLES cycles after the enables rise, neither flag asserts and no shutdown occurs, whatever the condition inputs do.
- R5: In latching mode (latch_mode_i=1), a fault (over_pwr_i or over_ref_i high) or a fail (under_pwr_i high) seen after blanking sets its flag and drops both enables 3 edges after the input rose.
- R6: After a latched shutdown, the enables stay 0 and both flags keep their values while disable_i stays low and supply_ok_i stays high, even when the conditions go away.
- R7: Asserting disable_i and then releasing it restarts the turn-on sequence. Both flags clear at the edge where that sequence starts.
- R8: Dropping supply_ok_i and raising it again restarts the turn-on sequence and clears both flags in the same way.
- R9: over_ref_i alone sets fault_o and leaves fail_o at 0.
- R10: When fault and fail are first seen in the same cycle, both flags latch together.
- R11: In non-latching mode (latch_mode_i=0), the enables stay high and each flag follows its condition with a 3-edge delay, clearing as soon as the condition goes away.
- R12: Once supply_ok_i has been low for 3 consecutive rising edges, both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| over_pwr_i | input | 1 | Over-power comparator result (fault condition) |
| under_pwr_i | input | 1 | Under-power comparator result (fail condition) |
| over_ref_i | input | 1 | Reference voltage too high (fault condition) |
| supply_ok_i | input | 1 | Supply above its good threshold |
| disable_i | input | 1 | High turns both laser currents off |
| latch_mode_i | input | 1 | 1 selects latching shutdown, 0 selects flags that follow the live conditions |
| bias_en_o | output | 1 | Laser bias current enable |
| mod_en_o | output | 1 | Laser modulation current enable |
| fault_o | output | 1 | Excess power flag, active high |
| fail_o | output | 1 | Low power flag, active high |

## Verification
The hardest states to reach are the ones where a condition arrives just as the blanking window closes, or at the same moment as a disable or a supply change. The timing has to land on the two-cycle synchronizer delay as well as the window counter. Directed sequences hold a condition high through turn-on and blanking, so that it trips on the first supervised cycle. They also raise both conditions on the same edge, and re-arm with both the disable toggle and the supply cycle. A long seeded random phase then changes the conditions, the disable, the supply and the mode at uneven rates, so that these events collide at every phase of the sequence. Every cycle of that phase is compared against a cycle model.

// File: rtl/laser_guard_pkg.sv
package laser_guard_pkg;
  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_TURN_ON  = 3'd1,
    ST_BLANK    = 3'd2,
    ST_RUN      = 3'd3,
    ST_SHUTDOWN = 3'd4
  } lg_state_e;

  typedef struct packed {
    logic latch;
    logic dis;
    logic sup;
    logic ovr;
    logic unp;
    logic ovp;
  } lg_in_t;
endpackage

// File: rtl/lg_sync.sv
module lg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lg_timer.sv
module lg_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lg_fsm.sv
module lg_fsm
  import laser_guard_pkg::*;
#(
  parameter int ON_CYCLES    = 16,
  parameter int BLANK_CYCLES = 64,
  parameter int CW           = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  lg_in_t        in_s_i,
  input  logic          zero_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output lg_state_e     state_o,
  output logic          en_o,
  output logic          fault_o,
  output logic          fail_o
);
  localparam logic [CW-1:0] OnLoad    = CW'(ON_CYCLES - 1);
  localparam logic [CW-1:0] BlankLoad = CW'(BLANK_CYCLES - 1);

  lg_state_e st_q, st_d;
  logic      fault_q, fault_d, fail_q, fail_d;
  logic      run_ok, det_fault, det_fail;

  assign run_ok    = in_s_i.sup & ~in_s_i.dis;
  assign det_fault = in_s_i.ovp | in_s_i.ovr;
  assign det_fail  = in_s_i.unp;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    fault_d    = fault_q;
    fail_d     = fail_q;
    unique case (st_q)
      ST_OFF: begin
        if (run_ok) begin
          st_d       = ST_TURN_ON;
          load_o     = 1'b1;
          load_val_o = OnLoad;
          fault_d    = 1'b0;
          fail_d     = 1'b0;
        end
      end
      ST_TURN_ON: begin
        fault_d = 1'b0;
        fail_d  = 1'b0;
        if (!run_ok) st_d = ST_OFF;
        else if (zero_i) begin
          st_d       = ST_BLANK;
          load_o     = 1'b1;
          load_val_o = BlankLoad;
        end
      end
      ST_BLANK: begin
        fault_d = 1'b0;
        fail_d  = 1'b0;
        if (!run_ok)     st_d = ST_OFF;
        else if (zero_i) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (!run_ok) st_d = ST_OFF;
        else begin
          // both modes report live detections; only latching mode trips
          fault_d = det_fault;
          fail_d  = det_fail;
          if (in_s_i.latch && (det_fault || det_fail)) st_d = ST_SHUTDOWN;
        end
      end
      ST_SHUTDOWN: begin
        if (!run_ok) st_d = ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_OFF;
      fault_q <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= fault_d;
      fail_q  <= fail_d;
    end
  end

  assign state_o = st_q;
  assign en_o    = (st_q == ST_BLANK) || (st_q == ST_RUN);
  assign fault_o = fault_q;
  assign fail_o  = fail_q;
endmodule

// File: rtl/laser_guard.sv
module laser_guard
  import laser_guard_pkg::*;
#(
  parameter int ON_CYCLES    = 16,
  parameter int BLANK_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic over_pwr_i,
  input  logic under_pwr_i,
  input  logic over_ref_i,
  input  logic supply_ok_i,
  input  logic disable_i,
  input  logic latch_mode_i,
  output logic bias_en_o,
  output logic mod_en_o,
  output logic fault_o,
  output logic fail_o
);
  localparam int MaxLen = (ON_CYCLES > BLANK_CYCLES) ? ON_CYCLES : BLANK_CYCLES;
  localparam int CW     = $clog2(MaxLen + 1);
  localparam int InW    = $bits(lg_in_t);

  lg_in_t        in_raw, in_s;
  logic [InW-1:0] in_s_vec;
  logic          tmr_load, tmr_zero, en;
  logic [CW-1:0] tmr_val;
  lg_state_e     state_q;
  logic          lat_s;

  assign in_raw = '{latch: latch_mode_i, dis: disable_i, sup: supply_ok_i,
                    ovr: over_ref_i, unp: under_pwr_i, ovp: over_pwr_i};

  lg_sync #(.W(InW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(in_raw), .q_o(in_s_vec)
  );
  assign in_s  = lg_in_t'(in_s_vec);
  assign lat_s = in_s.latch;

  lg_timer #(.CW(CW)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  lg_fsm #(.ON_CYCLES(ON_CYCLES), .BLANK_CYCLES(BLANK_CYCLES), .CW(CW)) u_fsm (
    .clk_i, .rst_ni, .in_s_i(in_s), .zero_i(tmr_zero),
    .load_o(tmr_load), .load_val_o(tmr_val), .state_o(state_q),
    .en_o(en), .fault_o(fault_o), .fail_o(fail_o)
  );

  assign bias_en_o = en;
  assign mod_en_o  = en;
endmodule

// File: rtl/lg_checker.sv
module lg_checker
  import laser_guard_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      disable_i,
  input logic      supply_ok_i,
  input logic      bias_en_o,
  input logic      mod_en_o,
  input logic      fault_o,
  input logic      fail_o,
  input logic      lat_s,
  input lg_state_e state_q
);
  assert_en_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bias_en_o == mod_en_o);

  assert_disable_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(disable_i, 1) && $past(disable_i, 2) && $past(disable_i, 3)) |-> !bias_en_o);

  assert_supply_off_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(supply_ok_i, 1) && !$past(supply_ok_i, 2) && !$past(supply_ok_i, 3)) |-> !bias_en_o);

  assert_turn_on_path_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bias_en_o) |-> $past(state_q) == ST_TURN_ON);

  assert_blank_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bias_en_o) |-> (!fault_o && !fail_o));

  assert_trip_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($rose(fault_o) || $rose(fail_o)) && $past(lat_s)) |-> !bias_en_o);

  assert_flags_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHUTDOWN && $past(state_q) == ST_SHUTDOWN)
      |-> ($stable(fault_o) && $stable(fail_o) && !bias_en_o));
endmodule

bind laser_guard lg_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .disable_i(disable_i), .supply_ok_i(supply_ok_i),
  .bias_en_o(bias_en_o), .mod_en_o(mod_en_o), .fault_o(fault_o), .fail_o(fail_o),
  .lat_s(lat_s), .state_q(state_q)
);

// File: tb/laser_guard_test.sv
module laser_guard_test;
  localparam int ON  = 3;
  localparam int BLK = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ovp = 0, unp = 0, ovr = 0, sup = 0, dis = 1, lat = 1;
  logic bias_en, mod_en, fault, fail;
  int   errors = 0, checks = 0;
  logic cmp_on = 1'b0;
  string cur_req = "R1";
  bit   done = 1'b0;

  always #5 clk = ~clk;

  laser_guard #(.ON_CYCLES(ON), .BLANK_CYCLES(BLK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .over_pwr_i(ovp), .under_pwr_i(unp),
    .over_ref_i(ovr), .supply_ok_i(sup), .disable_i(dis), .latch_mode_i(lat),
    .bias_en_o(bias_en), .mod_en_o(mod_en), .fault_o(fault), .fail_o(fail)
  );

  // Cycle model of the requirements: 2 edges of input delay, then the sequence
  logic [5:0] m1, m2;
  int m_st, m_cnt;
  logic m_f, m_l;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; m_st <= 0; m_cnt <= 0; m_f <= 0; m_l <= 0;
    end else begin
      logic ok, df, dl, lt;
      m1 <= {lat, dis, sup, ovr, unp, ovp};
      m2 <= m1;
      lt = m2[5]; ok = m2[3] && !m2[4]; df = m2[0] || m2[2]; dl = m2[1];
      case (m_st)
        0: if (ok) begin m_st <= 1; m_cnt <= ON; m_f <= 0; m_l <= 0; end
        1: if (!ok) m_st <= 0;
           else if (m_cnt == 1) begin m_st <= 2; m_cnt <= BLK; end
           else m_cnt <= m_cnt - 1;
        2: if (!ok) m_st <= 0;
           else if (m_cnt == 1) m_st <= 3;
           else m_cnt <= m_cnt - 1;
        3: if (!ok) m_st <= 0;
           else begin
             m_f <= df; m_l <= dl;
             if (lt && (df || dl)) m_st <= 4;
           end
        default: if (!ok) m_st <= 0;
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int men;
      men = (m_st == 2 || m_st == 3) ? 1 : 0;
      chk({cur_req, " model"}, {bias_en, mod_en, fault, fail}, {men[0], men[0], m_f, m_l});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts edges until the enable reaches the wanted level
  task automatic edges_to(input logic lvl, output int n);
    n = 0;
    while (bias_en !== lvl && n < 200) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    int unsigned r;
    r = $urandom(32'h5eed);
    cyc(3);
    chk("R1 reset", {bias_en, mod_en, fault, fail}, 0);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 after release", {bias_en, fault, fail}, 0);
    chk("R2 disable held", bias_en, 0);
    cmp_on = 1'b1;

    cur_req = "R3";
    sup = 1; dis = 0;
    edges_to(1'b1, n);
    chk("R3 turn-on edges", n, ON + 3);

    cur_req = "R4";
    ovp = 1;
    cyc(BLK - 3);
    chk("R4 no flag in blank", {fault, fail}, 0);
    chk("R4 still enabled in blank", bias_en, 1);
    edges_to(1'b0, n);
    chk("R5 fault flag", {fault, fail}, 2'b10);

    cur_req = "R6";
    ovp = 0;
    cyc(20);
    chk("R6 stays off", bias_en, 0);
    chk("R6 flag held", fault, 1);

    cur_req = "R7";
    dis = 1; cyc(4);
    chk("R7 flag kept while disabled", fault, 1);
    dis = 0; cyc(3);
    chk("R7 flag cleared at restart", fault, 0);
    edges_to(1'b1, n);
    chk("R7 re-enabled", bias_en, 1);
    cyc(BLK + 2);

    cur_req = "R5";
    unp = 1;
    edges_to(1'b0, n);
    chk("R5 trip latency", n, 3);
    chk("R5 fail flag", {fault, fail}, 2'b01);
    unp = 0;

    cur_req = "R8";
    sup = 0; cyc(4);
    chk("R12 supply low off", bias_en, 0);
    sup = 1; cyc(3);
    chk("R8 flags cleared", {fault, fail}, 0);
    edges_to(1'b1, n);
    chk("R8 re-enabled after supply cycle", bias_en, 1);
    cyc(BLK + 2);

    cur_req = "R10";
    ovp = 1; unp = 1;
    cyc(4);
    chk("R10 both latched", {bias_en, fault, fail}, 3'b011);
    ovp = 0; unp = 0;

    cur_req = "R9";
    dis = 1; cyc(4); dis = 0;
    edges_to(1'b1, n);
    cyc(BLK + 2);
    ovr = 1; cyc(4);
    chk("R9 over-reference fault", {bias_en, fault, fail}, 3'b010);
    ovr = 0;

    cur_req = "R11";
    lat = 0;
    dis = 1; cyc(4); dis = 0;
    edges_to(1'b1, n);
    cyc(BLK + 2);
    unp = 1; cyc(3);
    chk("R11 flag follows", {bias_en, fail}, 2'b11);
    unp = 0; cyc(3);
    chk("R11 flag clears", {bias_en, fail}, 2'b10);

    cur_req = "random";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(5) == 0) ovp = $urandom_range(3) == 0;
      if ($urandom_range(5) == 0) unp = $urandom_range(3) == 0;
      if ($urandom_range(40) == 0) ovr = ~ovr;
      if ($urandom_range(30) == 0) dis = ~dis;
      if ($urandom_range(60) == 0) sup = ~sup;
      if ($urandom_range(150) == 0) lat = ~lat;
      cyc(1);
    end
    finish_run();
  end
endmodule